// File: doc/BRIEF.md
# Serial Audio Shifter with Gated Bit Clock

This block is the bit-level engine of a serial audio port. It runs on the oversampling clock and derives a serial bit clock from it through a power-of-two divider, or takes the bit clock from an external pin after synchronising it. In transmit mode it takes parallel sample words through a valid/ready handshake, holds one word in reserve, and shifts each word out MSB first. In receive mode it assembles incoming serial bits into words and presents each finished word with a one-cycle valid strobe.

Control inputs select enable, direction, mute, compressed operation, burst gating and the divide code. With burst gating active in compressed transmit operation, clock pulses appear on the serial clock output only while a word is being shifted; between words the clock rests low. A data-request strobe warns the word source shortly before the current word runs out, so that back-to-back words leave no gap.

Each bit-clock phase lasts a whole number of oversampling cycles: divide code c gives phases of 2^c cycles, so one bit period is 2^(c+1) cycles.

Top module: `audio_serial_shifter`

## Requirements
- R1: After reset every output is low, rx_data is zero and tx_ready is low; all control inputs are expected at 0 out of reset.
- R2: With int_clk=1, divide code c (0 to 4) makes each high and each low phase of the bit clock last exactly 2^c clk cycles.
- R3: Divide codes 5, 6 and 7 behave exactly like code 0 and never stall the clock or the shifter.
- R4: With int_clk=0 the divide code is ignored, bit-clock edges come from ext_sck after a SYNC-stage synchroniser, and sck_out stays low.
- R5: While ctl_en=0 sck_out, sd_out, tx_ready, dreq and rx_valid are low and all counters are cleared; after ctl_en rises the first low phase of the bit clock is full length.
- R6: In transmit mode (ctl_tx=1) each word is driven MSB first, W bits per word; sd_out changes in the cycle in which the bit clock falls, and a word waiting in the buffer follows the previous word with no idle bit.
- R7: tx_ready is high exactly when enabled, transmitting and the one-word buffer is empty; a word is accepted in a cycle with tx_valid and tx_ready both high.
- R8: dreq is a one-cycle pulse in the cycle after the falling bit-clock edge that starts the second-to-last bit of a word.
- R9: ctl_mute=1 in transmit mode holds sd_out low while shifting and handshaking continue unchanged; in receive mode mute has no effect on received words.
- R10: In receive mode sd_in is sampled in the cycle in which the bit clock rises; after every W samples rx_data holds the word (first sample in the MSB) and rx_valid pulses for one cycle.
- R11: With ctl_burst=1, ctl_comp=1, transmit mode and the internal clock, sck_out shows pulses only while a word is active; ctl_burst without ctl_comp leaves the clock free-running.
- R12: sd_out is low in receive mode and whenever no transmit word is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Block enable |
| ctl_tx | input | 1 | Direction: 1 transmit, 0 receive |
| ctl_mute | input | 1 | Force transmit data low |
| ctl_comp | input | 1 | Compressed operation |
| ctl_burst | input | 1 | Gate bit clock to active words |
| ctl_div | input | 3 | Divide code |
| int_clk | input | 1 | 1: bit clock generated inside, 0: taken from ext_sck |
| ext_sck | input | 1 | External bit clock |
| tx_data | input | W | Word to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Buffer can take a word |
| dreq | output | 1 | Next word request pulse |
| sd_out | output | 1 | Serial data out |
| sck_out | output | 1 | Serial bit clock out |
| sd_in | input | 1 | Serial data in |
| rx_data | output | W | Last received word |
| rx_valid | output | 1 | rx_data updated this cycle |

## Verification
sck_out, sd_out and tx_ready react in the same cycle as the register update behind them, so a falling bit-clock strobe seen at one rising clk edge shows as a low sck_out and a new sd_out bit just after it; dreq and rx_valid appear one edge after the strobe that caused them, and an external clock edge reaches the strobe logic SYNC+1 edges after ext_sck moves. The bench keeps a behavioural model that advances at each rising edge from the same inputs and compares every output late in the low half of each clk period, so each result is checked in exactly the cycle it is due and never at the edge itself.

// File: rtl/sas_pkg.sv
package sas_pkg;

   typedef struct packed {
      logic       en;
      logic       tx;
      logic       mute;
      logic       comp;
      logic       burst;
      logic       intc;
      logic [2:0] div;
   } sas_ctl_t;

   // Phase length minus one for a divide code; out-of-range codes act as code 0.
   function automatic int unsigned phase_last(input logic [2:0] code, input int unsigned max_code);
      if (int'(code) <= int'(max_code)) return (32'd1 << code) - 32'd1;
      return 32'd0;
   endfunction

endpackage

// File: rtl/sas_bitclk.sv
module sas_bitclk
   import sas_pkg::*;
#(
   parameter int unsigned MAX_CODE = 4,
   parameter int unsigned SYNC     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic intc,
   input  logic [2:0] div,
   input  logic ext_sck,
   output logic phase,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int unsigned MAX_DIV = 1 << MAX_CODE;
   localparam int unsigned CW      = $clog2(MAX_DIV);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;
   logic          run;
   logic          wrap;
   logic [SYNC-1:0] sy;
   logic          lvl;
   logic          lvl_d;

   assign run  = en && intc;
   assign last = CW'(phase_last(div, MAX_CODE));
   assign wrap = run && (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (wrap) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < SYNC; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sy[0] <= 1'b0;
               else        sy[0] <= ext_sck;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sy[i] <= 1'b0;
               else        sy[i] <= sy[i-1];
            end
         end
      end
   endgenerate

   assign lvl = sy[SYNC-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   always_comb begin
      if (intc) begin
         rise_stb = wrap && !phase;
         fall_stb = wrap && phase;
      end else begin
         rise_stb = en && lvl && !lvl_d;
         fall_stb = en && !lvl && lvl_d;
      end
   end

endmodule

// File: rtl/sas_tx.sv
module sas_tx #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tx_mode,
   input  logic         fall_stb,
   input  logic [W-1:0] tx_data,
   input  logic         tx_valid,
   output logic         tx_ready,
   output logic         active,
   output logic         bit_out,
   output logic         dreq
);
   localparam int unsigned RW = $clog2(W + 1);

   logic [W-1:0]  hold;
   logic          full;
   logic [W-1:0]  sh, sh_nx;
   logic [RW-1:0] rem, rem_nx;
   logic          act_nx;
   logic          load;
   logic          accept;

   assign tx_ready = en && tx_mode && !full;
   assign accept   = tx_ready && tx_valid;
   assign bit_out  = active && sh[W-1];

   always_comb begin
      sh_nx  = sh;
      rem_nx = rem;
      act_nx = active;
      load   = 1'b0;
      if (tx_mode && fall_stb) begin
         if (rem > RW'(1)) begin
            sh_nx  = {sh[W-2:0], 1'b0};
            rem_nx = rem - 1'b1;
         end else if (full) begin
            sh_nx  = hold;
            rem_nx = RW'(W);
            act_nx = 1'b1;
            load   = 1'b1;
         end else begin
            act_nx = 1'b0;
            rem_nx = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold   <= '0;
         full   <= 1'b0;
         sh     <= '0;
         rem    <= '0;
         active <= 1'b0;
         dreq   <= 1'b0;
      end else if (!en) begin
         full   <= 1'b0;
         rem    <= '0;
         active <= 1'b0;
         dreq   <= 1'b0;
      end else begin
         sh     <= sh_nx;
         rem    <= rem_nx;
         active <= act_nx;
         dreq   <= tx_mode && fall_stb && (rem_nx == RW'(2));
         if (accept) begin
            hold <= tx_data;
            full <= 1'b1;
         end else if (load) begin
            full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sas_rx.sv
module sas_rx #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         rx_mode,
   input  logic         rise_stb,
   input  logic         sd_in,
   output logic [W-1:0] rx_data,
   output logic         rx_valid
);
   localparam int unsigned CW = $clog2(W);

   logic [W-1:0]  sh;
   logic [W-1:0]  word;
   logic [CW-1:0] cnt;
   logic          take;

   assign word = {sh[W-2:0], sd_in};
   assign take = rx_mode && rise_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         cnt      <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else if (!en) begin
         cnt      <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (take) begin
            sh <= word;
            if (cnt == CW'(W - 1)) begin
               cnt      <= '0;
               rx_data  <= word;
               rx_valid <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/audio_serial_shifter.sv
module audio_serial_shifter
   import sas_pkg::*;
#(
   parameter int unsigned W        = 16,
   parameter int unsigned MAX_CODE = 4,
   parameter int unsigned SYNC     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctl_en,
   input  logic         ctl_tx,
   input  logic         ctl_mute,
   input  logic         ctl_comp,
   input  logic         ctl_burst,
   input  logic [2:0]   ctl_div,
   input  logic         int_clk,
   input  logic         ext_sck,
   input  logic [W-1:0] tx_data,
   input  logic         tx_valid,
   output logic         tx_ready,
   output logic         dreq,
   output logic         sd_out,
   output logic         sck_out,
   input  logic         sd_in,
   output logic [W-1:0] rx_data,
   output logic         rx_valid
);
   generate
      if (W < 2)         begin : g_bad_w    $error("W must be at least 2");        end
      if (MAX_CODE < 1)  begin : g_bad_code $error("MAX_CODE must be 1 to 7");     end
      if (MAX_CODE > 7)  begin : g_big_code $error("MAX_CODE must be 1 to 7");     end
      if (SYNC < 2)      begin : g_bad_sync $error("SYNC must be at least 2");     end
   endgenerate

   sas_ctl_t ctl;
   logic     phase;
   logic     rise_stb;
   logic     fall_stb;
   logic     tx_active;
   logic     tx_bit;
   logic     gate_on;

   assign ctl = '{en: ctl_en, tx: ctl_tx, mute: ctl_mute, comp: ctl_comp,
                  burst: ctl_burst, intc: int_clk, div: ctl_div};

   sas_bitclk #(.MAX_CODE(MAX_CODE), .SYNC(SYNC)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctl.en),
      .intc     (ctl.intc),
      .div      (ctl.div),
      .ext_sck  (ext_sck),
      .phase    (phase),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   sas_tx #(.W(W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctl.en),
      .tx_mode  (ctl.tx),
      .fall_stb (fall_stb),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .active   (tx_active),
      .bit_out  (tx_bit),
      .dreq     (dreq)
   );

   sas_rx #(.W(W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctl.en),
      .rx_mode  (!ctl.tx),
      .rise_stb (rise_stb),
      .sd_in    (sd_in),
      .rx_data  (rx_data),
      .rx_valid (rx_valid)
   );

   assign gate_on = ctl.burst && ctl.comp && ctl.tx;
   assign sck_out = ctl.en && ctl.intc && phase && (!gate_on || tx_active);
   assign sd_out  = ctl.en && ctl.tx && !ctl.mute && tx_bit;

endmodule

// File: rtl/sas_chk.sv
module sas_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_en,
   input logic ctl_tx,
   input logic ctl_mute,
   input logic ctl_comp,
   input logic ctl_burst,
   input logic int_clk,
   input logic tx_valid,
   input logic tx_ready,
   input logic dreq,
   input logic sd_out,
   input logic sck_out,
   input logic rx_valid,
   input logic tx_busy
);
   a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> (!sck_out && !sd_out && !tx_ready));

   a_r9_mute_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_tx && ctl_mute) |-> !sd_out);

   a_r11_burst_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && int_clk && ctl_tx && ctl_comp && ctl_burst && !tx_busy) |-> !sck_out);

   a_r12_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_tx |-> !sd_out);

   a_r4_ext_no_sck: assert property (@(posedge clk) disable iff (!rst_n)
      !int_clk |-> !sck_out);

   a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r8_dreq_single: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |=> !dreq);

   a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

endmodule

bind audio_serial_shifter sas_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_en    (ctl_en),
   .ctl_tx    (ctl_tx),
   .ctl_mute  (ctl_mute),
   .ctl_comp  (ctl_comp),
   .ctl_burst (ctl_burst),
   .int_clk   (int_clk),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .dreq      (dreq),
   .sd_out    (sd_out),
   .sck_out   (sck_out),
   .rx_valid  (rx_valid),
   .tx_busy   (tx_active)
);

// File: tb/sim_audio_serial_shifter.sv
module sim_audio_serial_shifter;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int W        = 16;
   localparam int MAX_CODE = 4;
   localparam int SYNC     = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_en = 0, ctl_tx = 0, ctl_mute = 0, ctl_comp = 0, ctl_burst = 0;
   logic [2:0] ctl_div = 3'd0;
   logic int_clk = 1'b1, ext_sck = 1'b0, sd_in = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic tx_ready, dreq, sd_out, sck_out, rx_valid;
   logic [W-1:0] rx_data;

   audio_serial_shifter #(.W(W), .MAX_CODE(MAX_CODE), .SYNC(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_tx(ctl_tx), .ctl_mute(ctl_mute),
      .ctl_comp(ctl_comp), .ctl_burst(ctl_burst), .ctl_div(ctl_div), .int_clk(int_clk),
      .ext_sck(ext_sck), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .dreq(dreq), .sd_out(sd_out), .sck_out(sck_out), .sd_in(sd_in),
      .rx_data(rx_data), .rx_valid(rx_valid));

   always begin
      #2.5 clk = 1'b1;
      #2.5 clk = 1'b0;
   end

   int vectors = 0;
   int fails   = 0;
   string cur_req = "R1";
   bit started = 0;
   bit finished = 0;
   int dreq_seen = 0;
   int rxv_seen  = 0;

   // ---------------- reference model ----------------
   int m_cnt = 0;
   bit m_ph = 0, m_lvl_d = 0, m_full = 0, m_act = 0, m_dreq = 0, m_rxv = 0, m_acc = 0;
   bit m_sy [SYNC];
   logic [W-1:0] m_hold = '0, m_sh = '0, m_rsh = '0, m_rxd = '0;
   int m_rem = 0, m_rcnt = 0;

   always @(posedge clk) begin
      int  last;
      bit  rs, fl, lvl;
      started = 1;
      if (!rst_n) begin
         m_cnt = 0; m_ph = 0; m_lvl_d = 0; m_full = 0; m_act = 0; m_dreq = 0;
         m_rxv = 0; m_acc = 0; m_hold = '0; m_sh = '0; m_rsh = '0; m_rxd = '0;
         m_rem = 0; m_rcnt = 0;
         for (int i = 0; i < SYNC; i++) m_sy[i] = 0;
      end else begin
         last = (int'(ctl_div) <= MAX_CODE) ? (1 << ctl_div) - 1 : 0;
         lvl  = m_sy[SYNC-1];
         if (int_clk) begin
            rs = ctl_en && (m_cnt >= last) && !m_ph;
            fl = ctl_en && (m_cnt >= last) && m_ph;
         end else begin
            rs = ctl_en && lvl && !m_lvl_d;
            fl = ctl_en && !lvl && m_lvl_d;
         end
         if (!(ctl_en && int_clk)) begin m_cnt = 0; m_ph = 0; end
         else if (m_cnt >= last) begin m_cnt = 0; m_ph = !m_ph; end
         else m_cnt++;
         m_lvl_d = lvl;
         for (int i = SYNC - 1; i > 0; i--) m_sy[i] = m_sy[i-1];
         m_sy[0] = ext_sck;
         // transmit side
         m_acc = ctl_en && ctl_tx && tx_valid && !m_full;
         if (!ctl_en) begin
            m_full = 0; m_rem = 0; m_act = 0; m_dreq = 0;
         end else begin
            bit ld;
            ld = 0;
            m_dreq = 0;
            if (ctl_tx && fl) begin
               if (m_rem > 1) begin m_sh = m_sh << 1; m_rem--; end
               else if (m_full) begin m_sh = m_hold; m_rem = W; m_act = 1; ld = 1; end
               else begin m_act = 0; m_rem = 0; end
               m_dreq = (m_rem == 2);
            end
            if (m_acc) begin m_hold = tx_data; m_full = 1; end
            else if (ld) m_full = 0;
         end
         // receive side
         if (!ctl_en) begin
            m_rcnt = 0; m_rxv = 0;
         end else begin
            m_rxv = 0;
            if (!ctl_tx && rs) begin
               m_rsh = {m_rsh[W-2:0], sd_in};
               if (m_rcnt == W - 1) begin m_rcnt = 0; m_rxd = m_rsh; m_rxv = 1; end
               else m_rcnt++;
            end
         end
      end
   end

   task automatic cmp(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at %0t: actual %h expected %h", cur_req, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #2;
      if (started && !finished) begin
         bit e_sck, e_sd, e_rdy;
         e_sck = ctl_en && int_clk && m_ph && (!(ctl_burst && ctl_comp && ctl_tx) || m_act);
         e_sd  = ctl_en && ctl_tx && !ctl_mute && m_act && m_sh[W-1];
         e_rdy = ctl_en && ctl_tx && !m_full;
         cmp("sck_out",  W'(sck_out),  W'(e_sck));
         cmp("sd_out",   W'(sd_out),   W'(e_sd));
         cmp("tx_ready", W'(tx_ready), W'(e_rdy));
         cmp("dreq",     W'(dreq),     W'(m_dreq));
         cmp("rx_valid", W'(rx_valid), W'(m_rxv));
         cmp("rx_data",  rx_data,      m_rxd);
         if (dreq) dreq_seen++;
         if (rx_valid) rxv_seen++;
      end
   end

   // ---------------- stimulus helpers ----------------
   logic [W-1:0] txq [$];
   bit ext_run = 0;
   int ext_div = 0;
   logic [15:0] lfsr = 16'hACE1;

   always @(negedge clk) begin
      if (m_acc && txq.size() > 0) void'(txq.pop_front());
      tx_valid = (txq.size() > 0);
      tx_data  = (txq.size() > 0) ? txq[0] : '0;
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sd_in    = lfsr[0];
      if (ext_run) begin
         ext_div++;
         if (ext_div == 3) begin ext_div = 0; ext_sck = !ext_sck; end
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input int half);
      while (txq.size() > 0) @(negedge clk);
      run(2 * half * (2 * W + 4));
   endtask

   task automatic direct(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_ctl(input bit en, input bit tx, input bit mu, input bit cp,
                          input bit bu, input bit ic, input logic [2:0] dv);
      @(negedge clk);
      ctl_en = en; ctl_tx = tx; ctl_mute = mu; ctl_comp = cp;
      ctl_burst = bu; int_clk = ic; ctl_div = dv;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int hi_len;
      // R1: reset state
      cur_req = "R1";
      run(4);
      direct("R1", "rx_data after reset", int'(rx_data), 0);
      direct("R1", "tx_ready after reset", int'(tx_ready), 0);
      rst_n = 1'b1;
      run(4);

      // R6 / R7 / R8: transmit, code 0, back-to-back words
      cur_req = "R6";
      set_ctl(1, 1, 0, 0, 0, 1, 3'd0);
      txq.push_back(16'hA5C3); txq.push_back(16'h8001);
      txq.push_back(16'hFFFF); txq.push_back(16'h0000);
      cur_req = "R7";
      run(20);
      cur_req = "R8";
      drain(1);
      direct("R8", "dreq pulses seen", int'(dreq_seen >= 4), 1);

      // R2: other divide codes, with a measured high phase at code 2
      cur_req = "R2";
      set_ctl(0, 1, 0, 0, 0, 1, 3'd2);
      set_ctl(1, 1, 0, 0, 0, 1, 3'd2);
      txq.push_back(16'h1234); txq.push_back(16'hFEDC);
      while (!sck_out) @(negedge clk);
      hi_len = 0;
      while (sck_out) begin hi_len++; @(negedge clk); end
      direct("R2", "high phase length code 2", hi_len, 4);
      drain(4);
      set_ctl(1, 1, 0, 0, 0, 1, 3'd4);
      txq.push_back(16'h5A5A);
      drain(16);

      // R3: prohibited codes act as code 0
      cur_req = "R3";
      set_ctl(1, 1, 0, 0, 0, 1, 3'd6);
      txq.push_back(16'hC0DE); txq.push_back(16'h0F0F);
      drain(1);
      set_ctl(1, 1, 0, 0, 0, 1, 3'd7);
      txq.push_back(16'h3C3C);
      drain(1);

      // R5: disable mid-word, re-enable with code 1
      cur_req = "R5";
      set_ctl(1, 1, 0, 0, 0, 1, 3'd1);
      txq.push_back(16'hBEEF); txq.push_back(16'h4321);
      run(30);
      set_ctl(0, 1, 0, 0, 0, 1, 3'd1);
      run(10);
      txq.delete();
      set_ctl(1, 1, 0, 0, 0, 1, 3'd1);
      txq.push_back(16'h7E81);
      drain(2);

      // R9: mute while transmitting
      cur_req = "R9";
      set_ctl(1, 1, 1, 0, 0, 1, 3'd0);
      txq.push_back(16'hFFFF); txq.push_back(16'hAAAA);
      drain(1);

      // R11: burst gating with and without compressed mode
      cur_req = "R11";
      set_ctl(1, 1, 0, 1, 1, 1, 3'd1);
      txq.push_back(16'h9999);
      drain(2);
      run(40);
      txq.push_back(16'h6666); txq.push_back(16'h1111);
      drain(2);
      set_ctl(1, 1, 0, 0, 1, 1, 3'd1);
      txq.push_back(16'h2222);
      drain(2);

      // R10 / R12: receive, with mute set to show it has no effect
      cur_req = "R10";
      set_ctl(0, 0, 0, 0, 0, 1, 3'd0);
      set_ctl(1, 0, 0, 0, 0, 1, 3'd0);
      run(4 * 2 * W + 8);
      direct("R10", "rx words seen", int'(rxv_seen >= 3), 1);
      cur_req = "R12";
      set_ctl(1, 0, 1, 0, 0, 1, 3'd2);
      run(2 * 8 * W + 8);

      // R4: external bit clock, transmit then receive
      cur_req = "R4";
      ext_run = 1;
      set_ctl(0, 1, 0, 0, 0, 0, 3'd3);
      set_ctl(1, 1, 0, 1, 1, 0, 3'd3);
      txq.push_back(16'hD00D); txq.push_back(16'h0BAD);
      drain(3);
      set_ctl(0, 0, 0, 0, 0, 0, 3'd3);
      set_ctl(1, 0, 0, 0, 0, 0, 3'd3);
      run(2 * 6 * W + 20);
      set_ctl(0, 0, 0, 0, 0, 1, 3'd0);
      ext_run = 0;
      run(10);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule